// File: doc/BRIEF.md
# Profile Pin Word Selector

This block sits in the control path of a two-channel direct digital synthesizer. Each channel keeps its own bank of channel words, 16 words of 32 bits by default. The words are loaded through a plain write port that carries a channel number, a word index and a value. Four shared profile pins and a set of configuration fields decide which stored word each channel drives onto its output. The configuration fields are the modulation kind, the number of modulation levels, the pin split and the ramp pin claim. The output carries a tag that marks the word as amplitude, frequency or phase data.

The pins are split between the two channels. How they are split depends on the number of levels and on which pins the ramp-up/ramp-down function takes. The block also turns the claimed pins into per-channel ramp direction requests. It raises a flag when the ramp function takes the auxiliary data pins, because the serial port must then run one bit wide. A configuration error flag covers two cases: a pin mapping the block does not define, and linear sweep switched on while modulation is on.

Top module: `prof_word_sel`

## Requirements
- R1: `kind_o` carries the modulation kind one clock edge after the configuration is applied: 00 off, 01 amplitude, 10 frequency, 11 phase. It reads 00 while `cfg_err_o` is high.
- R2: With modulation kind 00, both channels output word 0 and `cfg_err_o` stays low.
- R3: With the level field at 00 (two levels), P2 picks word 0 or 1 of channel 0 and P3 picks word 0 or 1 of channel 1 when the ramp field is 00 or 11. With ramp field 10, P2 still drives channel 0 and channel 1 stays on word 0. Ramp field 01 is undefined.
- R4: With the level field at 01 (four levels), pin split 101 and ramp field 00 or 11, channel 0 uses index {P0,P1} and channel 1 uses {P2,P3}, with P0 and P2 as the MSBs. Any other pin split or ramp field, and level fields 10 and 11, are undefined.
- R5: An undefined mapping while modulation is on sets `cfg_err_o` and forces both channels to word 0.
- R6: Linear sweep enable together with a nonzero modulation kind sets `cfg_err_o`.
- R7: The ramp field picks the ramp pins. 00: none. 01: P2 drives channel 0 and P3 drives channel 1. 10: P3 drives both channels. 11: auxiliary pin 0 drives channel 0 and auxiliary pin 1 drives channel 1. For an active channel, `ramp_dn_o` follows its pin, so low means ramp up and high means ramp down. `ramp_act_o` shows the active channels.
- R8: `ser_1bit_o` is high exactly when the ramp field is 11.
- R9: A profile or auxiliary pin change reaches the outputs on the third rising edge. A configuration change reaches them on the next edge.
- R10: A write to the word a channel currently selects shows on that channel's output after the next edge. A write to any other word leaves the output unchanged.
- R11: While reset is low all outputs are zero and every stored word clears to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Word write strobe |
| wr_ch_i | input | 1 | Channel written |
| wr_idx_i | input | IDX_W | Word index written |
| wr_data_i | input | WORD_W | Word value |
| mod_type_i | input | 2 | Modulation kind |
| mod_lvl_i | input | 2 | Modulation level count |
| pin_cfg_i | input | 3 | Profile pin split |
| ramp_cfg_i | input | 2 | Ramp pin claim |
| sweep_en_i | input | 1 | Linear sweep enable |
| prof_i | input | 4 | Profile pins, bit n is Pn |
| aux_i | input | 3 | Auxiliary data pins |
| ch0_word_o | output | WORD_W | Channel 0 selected word |
| ch1_word_o | output | WORD_W | Channel 1 selected word |
| kind_o | output | 2 | Tag on the words |
| cfg_err_o | output | 1 | Configuration error |
| ser_1bit_o | output | 1 | Serial port forced one bit wide |
| ramp_act_o | output | 2 | Ramp pin active per channel |
| ramp_dn_o | output | 2 | Ramp down request per channel |

## Verification
The directed cases use banks filled with words that each carry their own channel and index. A wrong pin-to-channel mapping or a swapped index bit order therefore shows up as a specific wrong word. The worked four-level case (P0:P1 = 11, P2:P3 = 01) separates MSB-first from LSB-first ordering. The two-level cases with the ramp field set to 10 and 01 test whether the ramp claim on P3 correctly takes that pin away from channel 1. The random configurations mix legal and illegal level, split and ramp settings with sweep, checking that errors fall back to word 0. Timed checks after a single pin change, and writes to the selected word and to an unselected one, separate the synchronizer depth from the write bypass.

// File: rtl/pm_sel_pkg.sv
`timescale 1ns/1ps
package pm_sel_pkg;
  localparam int PROF_N = 4;
  localparam int AUX_N  = 3;
  localparam int NUM_CH = 2;

  typedef enum logic [1:0] {MOD_OFF = 2'b00, MOD_AMP = 2'b01, MOD_FREQ = 2'b10, MOD_PHASE = 2'b11} mod_kind_e;
  typedef enum logic [1:0] {LVL_2 = 2'b00, LVL_4 = 2'b01, LVL_8 = 2'b10, LVL_16 = 2'b11} mod_lvl_e;
  typedef enum logic [1:0] {RMP_NONE = 2'b00, RMP_P23 = 2'b01, RMP_P3 = 2'b10, RMP_AUX = 2'b11} ramp_map_e;

  localparam logic [2:0] PINCFG_SPLIT = 3'b101;
endpackage

// File: rtl/pm_sync.sv
`timescale 1ns/1ps
module pm_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pm_word_bank.sv
`timescale 1ns/1ps
module pm_word_bank #(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] mem_q [NUM_WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_data_i;
    end
  end

  // same-cycle write wins over stored value
  assign rd_data_o = (wr_en_i && wr_idx_i == rd_idx_i) ? wr_data_i : mem_q[rd_idx_i];

  AST_BANK_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_data_i)); // R10
endmodule

// File: rtl/pm_route.sv
`timescale 1ns/1ps
module pm_route
  import pm_sel_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  mod_kind_e          kind_i,
  input  mod_lvl_e           lvl_i,
  input  logic [2:0]         pin_cfg_i,
  input  ramp_map_e          ramp_i,
  input  logic               sweep_i,
  input  logic [PROF_N-1:0]  prof_i,
  input  logic [AUX_N-1:0]   aux_i,
  output logic [IDX_W-1:0]   idx0_o,
  output logic [IDX_W-1:0]   idx1_o,
  output logic               err_o,
  output logic [NUM_CH-1:0]  ramp_act_o,
  output logic [NUM_CH-1:0]  ramp_dn_o
);
  logic map_ok;
  logic pins_free;
  logic [IDX_W-1:0] idx0_raw, idx1_raw;

  assign pins_free = (ramp_i == RMP_NONE) || (ramp_i == RMP_AUX);

  always_comb begin
    idx0_raw = '0;
    idx1_raw = '0;
    map_ok   = 1'b0;
    unique case (lvl_i)
      LVL_2: begin
        if (pins_free) begin
          idx0_raw = IDX_W'(prof_i[2]);
          idx1_raw = IDX_W'(prof_i[3]);
          map_ok   = 1'b1;
        end else if (ramp_i == RMP_P3) begin
          idx0_raw = IDX_W'(prof_i[2]);
          map_ok   = 1'b1;
        end
      end
      LVL_4: begin
        if (pins_free && pin_cfg_i == PINCFG_SPLIT) begin
          idx0_raw = IDX_W'({prof_i[0], prof_i[1]});
          idx1_raw = IDX_W'({prof_i[2], prof_i[3]});
          map_ok   = 1'b1;
        end
      end
      default: map_ok = 1'b0;
    endcase
  end

  assign err_o  = (kind_i != MOD_OFF) && (sweep_i || !map_ok);
  assign idx0_o = (kind_i == MOD_OFF || err_o) ? '0 : idx0_raw;
  assign idx1_o = (kind_i == MOD_OFF || err_o) ? '0 : idx1_raw;

  always_comb begin
    ramp_act_o = '0;
    ramp_dn_o  = '0;
    unique case (ramp_i)
      RMP_NONE: ;
      RMP_P23: begin
        ramp_act_o = 2'b11;
        ramp_dn_o  = {prof_i[3], prof_i[2]};
      end
      RMP_P3: begin
        ramp_act_o = 2'b11;
        ramp_dn_o  = {prof_i[3], prof_i[3]};
      end
      RMP_AUX: begin
        ramp_act_o = 2'b11;
        ramp_dn_o  = {aux_i[1], aux_i[0]};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/prof_word_sel.sv
`timescale 1ns/1ps
module prof_word_sel
  import pm_sel_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int WORD_W    = 32,
  localparam int IDX_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_ch_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [1:0]        mod_type_i,
  input  logic [1:0]        mod_lvl_i,
  input  logic [2:0]        pin_cfg_i,
  input  logic [1:0]        ramp_cfg_i,
  input  logic              sweep_en_i,
  input  logic [3:0]        prof_i,
  input  logic [2:0]        aux_i,
  output logic [WORD_W-1:0] ch0_word_o,
  output logic [WORD_W-1:0] ch1_word_o,
  output logic [1:0]        kind_o,
  output logic              cfg_err_o,
  output logic              ser_1bit_o,
  output logic [1:0]        ramp_act_o,
  output logic [1:0]        ramp_dn_o
);
  localparam int PIN_W = PROF_N + AUX_N;

  logic [PIN_W-1:0]  pin_s;
  logic [IDX_W-1:0]  sel_idx [NUM_CH];
  logic [WORD_W-1:0] rd_word [NUM_CH];
  logic [WORD_W-1:0] word_q  [NUM_CH];
  logic              err_c;
  logic [NUM_CH-1:0] ract_c, rdn_c;

  logic [1:0]        kind_q;
  logic              err_q, ser_q;
  logic [NUM_CH-1:0] ract_q, rdn_q;

  pm_sync #(.W(PIN_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({aux_i, prof_i}),
    .q_o    (pin_s)
  );

  pm_route #(.IDX_W(IDX_W)) u_route (
    .kind_i     (mod_kind_e'(mod_type_i)),
    .lvl_i      (mod_lvl_e'(mod_lvl_i)),
    .pin_cfg_i  (pin_cfg_i),
    .ramp_i     (ramp_map_e'(ramp_cfg_i)),
    .sweep_i    (sweep_en_i),
    .prof_i     (pin_s[PROF_N-1:0]),
    .aux_i      (pin_s[PROF_N +: AUX_N]),
    .idx0_o     (sel_idx[0]),
    .idx1_o     (sel_idx[1]),
    .err_o      (err_c),
    .ramp_act_o (ract_c),
    .ramp_dn_o  (rdn_c)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic bank_we;
    assign bank_we = wr_en_i && (wr_ch_i == 1'(c));

    pm_word_bank #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (bank_we),
      .wr_idx_i  (wr_idx_i),
      .wr_data_i (wr_data_i),
      .rd_idx_i  (sel_idx[c]),
      .rd_data_o (rd_word[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) word_q[c] <= '0;
      else         word_q[c] <= rd_word[c];
    end

    AST_WRITE_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bank_we && wr_idx_i == sel_idx[c]) |=> word_q[c] == $past(wr_data_i)); // R10
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= '0;
      err_q  <= 1'b0;
      ser_q  <= 1'b0;
      ract_q <= '0;
      rdn_q  <= '0;
    end else begin
      kind_q <= err_c ? 2'b00 : mod_type_i;
      err_q  <= err_c;
      ser_q  <= (ramp_cfg_i == RMP_AUX);
      ract_q <= ract_c;
      rdn_q  <= rdn_c;
    end
  end

  assign ch0_word_o = word_q[0];
  assign ch1_word_o = word_q[1];
  assign kind_o     = kind_q;
  assign cfg_err_o  = err_q;
  assign ser_1bit_o = ser_q;
  assign ramp_act_o = ract_q;
  assign ramp_dn_o  = rdn_q;

  AST_SWEEP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sweep_en_i && mod_type_i != 2'b00) |=> cfg_err_o); // R6
  AST_OFF_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_type_i == 2'b00) |=> (kind_o == 2'b00 && !cfg_err_o)); // R2
  AST_ERR_UNTAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> kind_o == 2'b00); // R1
  AST_SER_ONEBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_cfg_i == 2'b11) |=> ser_1bit_o); // R8
  AST_NO_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ramp_cfg_i == 2'b00) |=> (ramp_act_o == 2'b00 && ramp_dn_o == 2'b00)); // R7
endmodule

// File: tb/sim_prof_word_sel.sv
`timescale 1ns/1ps
module sim_prof_word_sel;
  localparam int NW = 16;
  localparam int WW = 32;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        wr_ch_i = 1'b0;
  logic [3:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  mod_type_i = '0;
  logic [1:0]  mod_lvl_i = '0;
  logic [2:0]  pin_cfg_i = '0;
  logic [1:0]  ramp_cfg_i = '0;
  logic        sweep_en_i = 1'b0;
  logic [3:0]  prof_i = '0;
  logic [2:0]  aux_i = '0;
  logic [31:0] ch0_word_o, ch1_word_o;
  logic [1:0]  kind_o;
  logic        cfg_err_o, ser_1bit_o;
  logic [1:0]  ramp_act_o, ramp_dn_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [2][NW];

  always #2 clk_i = ~clk_i;

  prof_word_sel #(.NUM_WORDS(NW), .WORD_W(WW)) u0 (.*);

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  function automatic void calc(input logic [1:0] mt, lv, rc, input logic [2:0] pc, input logic sw,
                               input logic [3:0] p, input logic [2:0] a,
                               output int i0, output int i1, output logic er,
                               output logic [1:0] act, output logic [1:0] dn);
    logic ok;
    i0 = 0; i1 = 0; ok = 1'b0;
    if (lv == 2'b00) begin
      if (rc == 2'b00 || rc == 2'b11) begin ok = 1'b1; i0 = int'(p[2]); i1 = int'(p[3]); end
      else if (rc == 2'b10) begin ok = 1'b1; i0 = int'(p[2]); end
    end else if (lv == 2'b01 && pc == 3'b101 && (rc == 2'b00 || rc == 2'b11)) begin
      ok = 1'b1;
      i0 = 2 * int'(p[0]) + int'(p[1]);
      i1 = 2 * int'(p[2]) + int'(p[3]);
    end
    er = (mt != 2'b00) && (sw || !ok);
    if (mt == 2'b00 || er) begin i0 = 0; i1 = 0; end
    case (rc)
      2'b00:   begin act = 2'b00; dn = 2'b00; end
      2'b01:   begin act = 2'b11; dn = {p[3], p[2]}; end
      2'b10:   begin act = 2'b11; dn = {p[3], p[3]}; end
      default: begin act = 2'b11; dn = {a[1], a[0]}; end
    endcase
  endfunction

  task automatic check_all(input string rq);
    int i0, i1;
    logic er;
    logic [1:0] act, dn;
    calc(mod_type_i, mod_lvl_i, ramp_cfg_i, pin_cfg_i, sweep_en_i, prof_i, aux_i, i0, i1, er, act, dn);
    chk(rq, "ch0 word", ch0_word_o, mem[0][i0]);
    chk(rq, "ch1 word", ch1_word_o, mem[1][i1]);
    chk("R1", "kind", 32'(kind_o), er ? 32'd0 : 32'(mod_type_i));
    chk("R5", "cfg_err", 32'(cfg_err_o), 32'(er));
    chk("R8", "ser_1bit", 32'(ser_1bit_o), 32'(ramp_cfg_i == 2'b11));
    chk("R7", "ramp_act", 32'(ramp_act_o), 32'(act));
    chk("R7", "ramp_dn", 32'(ramp_dn_o), 32'(dn));
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic set_cfg(input logic [1:0] mt, lv, input logic [2:0] pc, input logic [1:0] rc, input logic sw);
    mod_type_i = mt; mod_lvl_i = lv; pin_cfg_i = pc; ramp_cfg_i = rc; sweep_en_i = sw;
  endtask

  task automatic wr(input logic ch, input logic [3:0] idx, input logic [31:0] d);
    wr_en_i = 1'b1; wr_ch_i = ch; wr_idx_i = idx; wr_data_i = d;
    mem[ch][idx] = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] x;
    void'($urandom(32'd24681));
    for (int c = 0; c < 2; c++) for (int i = 0; i < NW; i++) mem[c][i] = '0;

    // R11: reset state
    prof_i = 4'hF; aux_i = 3'h7;
    cyc(3);
    chk("R11", "ch0 in reset", ch0_word_o, 32'd0);
    chk("R11", "ch1 in reset", ch1_word_o, 32'd0);
    chk("R11", "flags in reset", {24'd0, kind_o, cfg_err_o, ser_1bit_o, ramp_act_o, ramp_dn_o}, 32'd0);
    rst_ni = 1'b1;
    prof_i = 4'h0; aux_i = 3'h0;
    cyc(4);
    chk("R11", "cleared bank word 0", ch0_word_o, 32'd0);

    for (int c = 0; c < 2; c++)
      for (int i = 0; i < NW; i++)
        wr(1'(c), 4'(i), ($urandom() & 32'hFFFF_FF00) | 32'(c * 16 + i));

    // R2: modulation off
    set_cfg(2'b00, 2'b01, 3'b101, 2'b00, 1'b0); prof_i = 4'b1111;
    cyc(4); check_all("R2");

    // R3: two-level, ramp variants
    set_cfg(2'b10, 2'b00, 3'b000, 2'b00, 1'b0); prof_i = 4'b0100;
    cyc(4); check_all("R3");
    prof_i = 4'b1000; cyc(4); check_all("R3");
    set_cfg(2'b10, 2'b00, 3'b000, 2'b10, 1'b0); prof_i = 4'b1100;
    cyc(4); check_all("R3");
    set_cfg(2'b01, 2'b00, 3'b000, 2'b01, 1'b0);
    cyc(4); check_all("R3");

    // R4: four-level split, worked example
    set_cfg(2'b11, 2'b01, 3'b101, 2'b00, 1'b0); prof_i = 4'b1011;
    cyc(4); check_all("R4");
    chk("R4", "ch0 word 3", ch0_word_o, mem[0][3]);
    chk("R4", "ch1 word 1", ch1_word_o, mem[1][1]);

    // R9: pin latency
    prof_i = 4'b0000;
    cyc(2); chk("R9", "ch0 before third edge", ch0_word_o, mem[0][3]);
    cyc(1); chk("R9", "ch0 at third edge", ch0_word_o, mem[0][0]);

    // R4: unsupported split / level
    set_cfg(2'b11, 2'b01, 3'b011, 2'b00, 1'b0); prof_i = 4'b1111;
    cyc(4); check_all("R4");
    set_cfg(2'b10, 2'b10, 3'b101, 2'b00, 1'b0);
    cyc(4); check_all("R4");

    // R10: write bypass to the selected word; write elsewhere ignored
    set_cfg(2'b10, 2'b01, 3'b101, 2'b00, 1'b0); prof_i = 4'b0110;
    cyc(4);
    x = 32'hDEAD_0001;
    wr(1'b0, 4'd1, x);
    chk("R10", "ch0 after selected write", ch0_word_o, x);
    wr(1'b1, 4'd7, 32'hBEEF_0007);
    chk("R10", "ch1 after unselected write", ch1_word_o, mem[1][2]);
    cyc(2); check_all("R10");

    // R6 / R9: sweep conflict, config latency one edge
    sweep_en_i = 1'b1;
    cyc(1);
    chk("R6", "sweep error", 32'(cfg_err_o), 32'd1);
    chk("R9", "config to word in one edge", ch0_word_o, mem[0][0]);
    cyc(2); check_all("R6");

    // R7 / R8: ramp on auxiliary pins
    set_cfg(2'b01, 2'b00, 3'b000, 2'b11, 1'b0); aux_i = 3'b110; prof_i = 4'b0100;
    cyc(4); check_all("R8");
    aux_i = 3'b001; cyc(4); check_all("R7");
    set_cfg(2'b00, 2'b00, 3'b000, 2'b01, 1'b0); prof_i = 4'b1000;
    cyc(4); check_all("R7");

    // random mix
    for (int it = 0; it < 400; it++) begin
      logic [1:0] lv;
      lv = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(2, 3)) : 2'($urandom_range(0, 1));
      set_cfg(2'($urandom_range(0, 3)), lv,
              ($urandom_range(0, 1) == 1) ? 3'b101 : 3'($urandom_range(0, 7)),
              2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0));
      prof_i = 4'($urandom_range(0, 15));
      aux_i  = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 1) == 1)
        wr(1'($urandom_range(0, 1)), 4'($urandom_range(0, 15)), $urandom());
      cyc(4);
      check_all((lv == 2'b00) ? "R3" : "R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule